// File: doc/BRIEF.md
# AHB-Lite Slave-Side Protocol Monitor

A passive, synthesizable observer for one AHB-Lite slave port. It never drives the bus. Every rising clock edge it samples the master's control signals (transfer type, direction, address, size and, when configured, the slave select and the incoming ready). It also samples the slave's ready and response. From these it finds transfers that the slave stalls, and records the control values of each one. It then checks that the master keeps those values fixed until the slave finishes.

Separately, it checks the shape of an ERROR response: the completing half of an error must follow a not-ready sample. Each kind of violation sets a flag that stays set until reset and also produces a pulse for each offending sample. Each stalled transfer that completes produces a one-cycle report carrying the recorded attributes. A verification environment or an on-chip debug block can use the flags, pulses and reports. All outputs are registered. A sample taken at one edge shows on the outputs straight after that edge.

Top module: `ahbl_proto_mon`

## Requirements
- R1: A sample records a transfer as pending only when all of these hold: no transfer is already pending, the slave ready is 0, the select is 1, the incoming ready is 1, and the transfer type is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00) and BUSY (2'b01) are never recorded.
- R2: A qualifying transfer sampled while the slave ready is 1 is not recorded, so no completion report follows it.
- R3: While a transfer is pending, the first sample with the slave ready at 1 completes it. After that edge `done_vld` is 1 for exactly one cycle and carries the recorded type, direction, address, size and select. The pending state is then cleared.
- R4: In every sample while a transfer is pending, including the completing one, a difference between any recorded field (address, direction, size, select, type) and its live value sets `stab_pulse` for that cycle and sets `stab_flag`. A matching sample leaves `stab_pulse` at 0.
- R5: A change of transfer type in a sample where the response is ERROR (1) does not count as a stability violation. OKAY is 0.
- R6: A sample with slave ready 1 and response ERROR, whose previous sample also had slave ready 1, sets `err_pulse` for that cycle and sets `err_flag`. Reset sets the remembered previous ready to 1.
- R7: The synchronous active-high reset clears the pending transfer, both flags, both pulses and the completion report. Outside reset, a flag that has been set never returns to 0.
- R8: When a pending transfer has waited through 1 to N not-ready samples, exactly one completion report is produced, and only in the cycle after the first ready sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst | input | 1 | Synchronous reset, active high |
| htrans | input | 2 | Transfer type from the master |
| hwrite | input | 1 | Direction, 1 = write |
| haddr | input | ADDR_W | Transfer address |
| hsize | input | 3 | Transfer size code |
| hsel | input | 1 | Slave select (used when HAS_SEL=1) |
| hready_in | input | 1 | Incoming ready (used when HAS_RDYIN=1) |
| hready | input | 1 | Slave ready output being observed |
| hresp | input | 1 | Slave response, 1 = ERROR |
| stab_flag | output | 1 | Sticky control-stability violation |
| err_flag | output | 1 | Sticky error-shape violation |
| stab_pulse | output | 1 | Stability violation in the last sample |
| err_pulse | output | 1 | Error-shape violation in the last sample |
| done_vld | output | 1 | Completion report valid |
| done_trans | output | 2 | Recorded transfer type |
| done_write | output | 1 | Recorded direction |
| done_addr | output | ADDR_W | Recorded address |
| done_size | output | 3 | Recorded size |
| done_sel | output | 1 | Recorded select |

## Verification
The bound checker watches, on every cycle, the relations that link outputs to the sampled bus. A set flag never falls outside reset. A pulse always comes with its flag. An error-shape pulse follows any ready ERROR sample that was preceded by a ready sample. A completion report only follows a ready sample and never repeats in back-to-back cycles. Only the bench scenarios can show which qualifier combinations really record a transfer, that the reported attributes equal the stalled ones, and that the type exemption under ERROR holds. They also show that each single-field change is caught, including a change in the completing sample.

// File: rtl/ahbl_mon_pkg.sv
package ahbl_mon_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

  localparam int SIZE_W  = 3;
  localparam int TRANS_W = 2;

  // NONSEQ and SEQ both carry the high bit of the type code
  function automatic logic is_active(input logic [TRANS_W-1:0] t);
    return t[1];
  endfunction

endpackage

// File: rtl/ahbl_qual.sv
module ahbl_qual
  import ahbl_mon_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit HAS_SEL   = 1'b1,
  parameter bit HAS_RDYIN = 1'b1
) (
  input  logic [TRANS_W-1:0] htrans,
  input  logic               hwrite,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [SIZE_W-1:0]  hsize,
  input  logic               hsel,
  input  logic               hready_in,
  output logic               ctrl_known,
  output logic               qual
);

  localparam int CTRL_W = TRANS_W + 1 + ADDR_W + SIZE_W;

  logic [CTRL_W-1:0] ctrl_bus;
  logic              sel_ok;
  logic              rin_ok;
  logic              sel_known;
  logic              rin_known;

  assign ctrl_bus = {htrans, hwrite, haddr, hsize};

  generate
    if (HAS_SEL) begin : g_sel
      assign sel_ok    = hsel;
      assign sel_known = !$isunknown(hsel);
    end else begin : g_nosel
      assign sel_ok    = 1'b1;
      assign sel_known = 1'b1;
    end

    if (HAS_RDYIN) begin : g_rin
      assign rin_ok    = hready_in;
      assign rin_known = !$isunknown(hready_in);
    end else begin : g_norin
      assign rin_ok    = 1'b1;
      assign rin_known = 1'b1;
    end
  endgenerate

  always_comb begin
    ctrl_known = !$isunknown(ctrl_bus) && sel_known && rin_known;
    qual       = ctrl_known && is_active(htrans) && sel_ok && rin_ok;
  end

endmodule

// File: rtl/ahbl_track.sv
module ahbl_track
  import ahbl_mon_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit HAS_SEL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               qual,
  input  logic               ctrl_known,
  input  logic [TRANS_W-1:0] htrans,
  input  logic               hwrite,
  input  logic [ADDR_W-1:0]  haddr,
  input  logic [SIZE_W-1:0]  hsize,
  input  logic               hsel,
  input  logic               hready,
  input  logic               hresp,
  output logic               stab_hit,
  output logic               done_vld,
  output logic [TRANS_W-1:0] done_trans,
  output logic               done_write,
  output logic [ADDR_W-1:0]  done_addr,
  output logic [SIZE_W-1:0]  done_size,
  output logic               done_sel
);

  logic               pend_q;
  logic [TRANS_W-1:0] cap_trans_q;
  logic               cap_write_q;
  logic [ADDR_W-1:0]  cap_addr_q;
  logic [SIZE_W-1:0]  cap_size_q;
  logic               cap_sel_q;

  logic trans_diff;
  logic sel_diff;
  logic field_diff;
  logic take;
  logic finish;

  generate
    if (HAS_SEL) begin : g_selcmp
      assign sel_diff = (hsel != cap_sel_q);
    end else begin : g_noselcmp
      assign sel_diff = 1'b0;
    end
  endgenerate

  always_comb begin
    // type changes are tolerated while the slave signals ERROR
    trans_diff = (htrans != cap_trans_q) && (hresp != RESP_ERROR);
    field_diff = trans_diff || (hwrite != cap_write_q) ||
                 (haddr != cap_addr_q) || (hsize != cap_size_q) || sel_diff;
    stab_hit   = pend_q && (field_diff || !ctrl_known);
    take       = !pend_q && qual && !hready;
    finish     = pend_q && hready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      cap_trans_q <= TR_IDLE;
      cap_write_q <= 1'b0;
      cap_addr_q  <= '0;
      cap_size_q  <= '0;
      cap_sel_q   <= 1'b0;
    end else begin
      if (take) begin
        pend_q      <= 1'b1;
        cap_trans_q <= htrans;
        cap_write_q <= hwrite;
        cap_addr_q  <= haddr;
        cap_size_q  <= hsize;
        cap_sel_q   <= HAS_SEL ? hsel : 1'b1;
      end else if (finish) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_vld   <= 1'b0;
      done_trans <= TR_IDLE;
      done_write <= 1'b0;
      done_addr  <= '0;
      done_size  <= '0;
      done_sel   <= 1'b0;
    end else begin
      done_vld <= finish;
      if (finish) begin
        done_trans <= cap_trans_q;
        done_write <= cap_write_q;
        done_addr  <= cap_addr_q;
        done_size  <= cap_size_q;
        done_sel   <= cap_sel_q;
      end
    end
  end

endmodule

// File: rtl/ahbl_errshape.sv
module ahbl_errshape
  import ahbl_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hready,
  input  logic hresp,
  output logic err_hit
);

  logic prev_rdy_q;

  // the ready half of an ERROR must follow a not-ready sample
  assign err_hit = hready && (hresp == RESP_ERROR) && prev_rdy_q;

  always_ff @(posedge clk) begin
    if (rst) prev_rdy_q <= 1'b1;
    else     prev_rdy_q <= hready;
  end

endmodule

// File: rtl/ahbl_proto_mon.sv
module ahbl_proto_mon
  import ahbl_mon_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter bit HAS_SEL   = 1'b1,
  parameter bit HAS_RDYIN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [2:0]        hsize,
  input  logic              hsel,
  input  logic              hready_in,
  input  logic              hready,
  input  logic              hresp,
  output logic              stab_flag,
  output logic              err_flag,
  output logic              stab_pulse,
  output logic              err_pulse,
  output logic              done_vld,
  output logic [1:0]        done_trans,
  output logic              done_write,
  output logic [ADDR_W-1:0] done_addr,
  output logic [2:0]        done_size,
  output logic              done_sel
);

  logic ctrl_known;
  logic qual;
  logic stab_hit;
  logic err_hit;

  ahbl_qual #(
    .ADDR_W   (ADDR_W),
    .HAS_SEL  (HAS_SEL),
    .HAS_RDYIN(HAS_RDYIN)
  ) u_qual (
    .htrans    (htrans),
    .hwrite    (hwrite),
    .haddr     (haddr),
    .hsize     (hsize),
    .hsel      (hsel),
    .hready_in (hready_in),
    .ctrl_known(ctrl_known),
    .qual      (qual)
  );

  ahbl_track #(
    .ADDR_W (ADDR_W),
    .HAS_SEL(HAS_SEL)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .qual      (qual),
    .ctrl_known(ctrl_known),
    .htrans    (htrans),
    .hwrite    (hwrite),
    .haddr     (haddr),
    .hsize     (hsize),
    .hsel      (hsel),
    .hready    (hready),
    .hresp     (hresp),
    .stab_hit  (stab_hit),
    .done_vld  (done_vld),
    .done_trans(done_trans),
    .done_write(done_write),
    .done_addr (done_addr),
    .done_size (done_size),
    .done_sel  (done_sel)
  );

  ahbl_errshape u_err (
    .clk    (clk),
    .rst    (rst),
    .hready (hready),
    .hresp  (hresp),
    .err_hit(err_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stab_flag  <= 1'b0;
      err_flag   <= 1'b0;
      stab_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      stab_pulse <= stab_hit;
      err_pulse  <= err_hit;
      stab_flag  <= stab_flag | stab_hit;
      err_flag   <= err_flag | err_hit;
    end
  end

endmodule

// File: rtl/ahbl_proto_mon_chk.sv
module ahbl_proto_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       hready,
  input logic       hresp,
  input logic       stab_flag,
  input logic       err_flag,
  input logic       stab_pulse,
  input logic       err_pulse,
  input logic       done_vld,
  input logic [1:0] done_trans
);

  // R7
  stab_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(stab_flag));

  // R7
  err_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(err_flag));

  // R4
  stab_pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stab_pulse |-> stab_flag);

  // R6
  err_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && hready && hresp && $past(hready)) |=> (err_pulse && err_flag));

  // R3
  done_after_ready_chk: assert property (@(posedge clk) disable iff (rst)
    done_vld |-> $past(hready));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_vld |=> !done_vld);

  // R1
  done_active_type_chk: assert property (@(posedge clk) disable iff (rst)
    done_vld |-> done_trans[1]);

endmodule

bind ahbl_proto_mon ahbl_proto_mon_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hready    (hready),
  .hresp     (hresp),
  .stab_flag (stab_flag),
  .err_flag  (err_flag),
  .stab_pulse(stab_pulse),
  .err_pulse (err_pulse),
  .done_vld  (done_vld),
  .done_trans(done_trans)
);

// File: tb/ahbl_proto_mon_tb.sv
module ahbl_proto_mon_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    htrans = 2'b00;
  logic          hwrite = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [2:0]    hsize = 3'd0;
  logic          hsel = 1'b0;
  logic          hready_in = 1'b1;
  logic          hready = 1'b1;
  logic          hresp = 1'b0;
  logic          stab_flag, err_flag, stab_pulse, err_pulse, done_vld;
  logic [1:0]    done_trans;
  logic          done_write, done_sel;
  logic [AW-1:0] done_addr;
  logic [2:0]    done_size;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahbl_proto_mon #(.ADDR_W(AW), .HAS_SEL(1'b1), .HAS_RDYIN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .htrans(htrans), .hwrite(hwrite), .haddr(haddr),
    .hsize(hsize), .hsel(hsel), .hready_in(hready_in), .hready(hready),
    .hresp(hresp), .stab_flag(stab_flag), .err_flag(err_flag),
    .stab_pulse(stab_pulse), .err_pulse(err_pulse), .done_vld(done_vld),
    .done_trans(done_trans), .done_write(done_write), .done_addr(done_addr),
    .done_size(done_size), .done_sel(done_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one sample, then wait until just after the edge that takes it
  task automatic step(input logic [1:0] t, input logic w, input logic [AW-1:0] a,
                      input logic [2:0] s, input logic sl, input logic ri,
                      input logic rdy, input logic rsp);
    @(negedge clk);
    htrans = t; hwrite = w; haddr = a; hsize = s;
    hsel = sl; hready_in = ri; hready = rdy; hresp = rsp;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    htrans = 2'b00; hready = 1'b1; hresp = 1'b0; hsel = 1'b0; hready_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R7 reset state
    check("R7 stab_flag after reset", {31'd0, stab_flag}, 32'd0);
    check("R7 err_flag after reset", {31'd0, err_flag}, 32'd0);
    check("R7 done_vld after reset", {31'd0, done_vld}, 32'd0);

    // R1 sweep over type, select and incoming ready
    for (int c = 0; c < 16; c++) begin
      logic [1:0] t;
      logic sl, ri, exp;
      logic [AW-1:0] a;
      t = c[1:0]; sl = c[2]; ri = c[3];
      a = AW'(c * 37 + 5);
      exp = t[1] & sl & ri;
      step(t, c[0], a, 3'(c % 3), sl, ri, 1'b0, 1'b0);
      check("R1 no report while stalled", {31'd0, done_vld}, 32'd0);
      step(t, c[0], a, 3'(c % 3), sl, ri, 1'b1, 1'b0);
      check("R1 report iff qualified", {31'd0, done_vld}, {31'd0, exp});
      if (exp) begin
        check("R3 addr", {20'd0, done_addr}, {20'd0, a});
        check("R3 trans", {30'd0, done_trans}, {30'd0, t});
        check("R3 size", {29'd0, done_size}, {29'd0, 3'(c % 3)});
      end
    end
    check("R4 no stab in clean sweep", {31'd0, stab_flag}, 32'd0);

    // R2 zero-wait transfer is not recorded
    step(2'b10, 1'b1, 12'h0AB, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0);
    step(2'b00, 1'b0, 12'h000, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R2 no report for zero-wait", {31'd0, done_vld}, 32'd0);

    // R8 wait-state sweep
    for (int w = 0; w < 2; w++) begin
      for (int n = 1; n <= 4; n++) begin
        logic [AW-1:0] a;
        a = AW'(n * 256 + w * 16 + 4);
        step(2'b10, w[0], a, 3'(n - 1), 1'b1, 1'b1, 1'b0, 1'b0);
        for (int k = 1; k < n; k++) begin
          step(2'b10, w[0], a, 3'(n - 1), 1'b1, 1'b1, 1'b0, 1'b0);
          check("R8 no early report", {31'd0, done_vld}, 32'd0);
        end
        step(2'b10, w[0], a, 3'(n - 1), 1'b1, 1'b1, 1'b1, 1'b0);
        check("R8 one report", {31'd0, done_vld}, 32'd1);
        check("R3 write", {31'd0, done_write}, {31'd0, w[0]});
        check("R3 sel", {31'd0, done_sel}, 32'd1);
        check("R3 addr after waits", {20'd0, done_addr}, {20'd0, a});
        step(2'b00, 1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 report lasts one cycle", {31'd0, done_vld}, 32'd0);
      end
    end
    check("R4 no stab in wait sweep", {31'd0, stab_flag}, 32'd0);

    // R4 single-field change while stalled, then on the completing sample
    for (int f = 0; f < 5; f++) begin
      for (int at_end = 0; at_end < 2; at_end++) begin
        logic [1:0] t2; logic w2; logic [AW-1:0] a2; logic [2:0] s2; logic sl2;
        do_reset();
        t2 = 2'b10; w2 = 1'b0; a2 = 12'h340; s2 = 3'd1; sl2 = 1'b1;
        step(2'b10, 1'b0, 12'h340, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0);
        case (f)
          0: a2 = 12'h341;
          1: w2 = 1'b1;
          2: s2 = 3'd2;
          3: sl2 = 1'b0;
          default: t2 = 2'b11;
        endcase
        if (at_end == 0) begin
          step(t2, w2, a2, s2, sl2, 1'b1, 1'b0, 1'b0);
          check("R4 pulse on change", {31'd0, stab_pulse}, 32'd1);
          step(2'b10, 1'b0, 12'h340, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0);
          check("R4 pulse clears on match", {31'd0, stab_pulse}, 32'd0);
          check("R7 stab_flag sticky", {31'd0, stab_flag}, 32'd1);
        end else begin
          step(t2, w2, a2, s2, sl2, 1'b1, 1'b1, 1'b0);
          check("R4 change in completing sample", {31'd0, stab_pulse}, 32'd1);
          check("R3 still reports", {31'd0, done_vld}, 32'd1);
        end
      end
    end

    // R7 reset drops the pending transfer
    do_reset();
    step(2'b10, 1'b0, 12'h111, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    do_reset();
    check("R7 flag cleared", {31'd0, stab_flag}, 32'd0);
    step(2'b10, 1'b0, 12'h111, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R7 pending cleared by reset", {31'd0, done_vld}, 32'd0);

    // R5 type change under ERROR, with a correct two-cycle error
    step(2'b11, 1'b1, 12'h220, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    step(2'b00, 1'b1, 12'h220, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R5 no stab on type change under ERROR", {31'd0, stab_pulse}, 32'd0);
    step(2'b00, 1'b1, 12'h220, 3'd2, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R5 no stab at ERROR completion", {31'd0, stab_flag}, 32'd0);
    check("R6 proper error shape accepted", {31'd0, err_flag}, 32'd0);
    check("R3 error completion reported", {31'd0, done_vld}, 32'd1);
    check("R3 recorded type kept", {30'd0, done_trans}, 32'd3);

    // R6 single-cycle error right after reset (previous ready taken as 1)
    do_reset();
    step(2'b00, 1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R6 err pulse", {31'd0, err_pulse}, 32'd1);
    check("R6 err flag", {31'd0, err_flag}, 32'd1);
    step(2'b00, 1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R6 pulse one cycle", {31'd0, err_pulse}, 32'd0);
    check("R7 err flag sticky", {31'd0, err_flag}, 32'd1);
    step(2'b00, 1'b0, '0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R6 err after ready OKAY", {31'd0, err_pulse}, 32'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule